// File: doc/BRIEF.md
# Register Write Reservation Scoreboard

This block keeps, for every architectural register, a record of two kinds of in-flight activity: whether an issued instruction still owes the register a result, and how many issued instructions have yet to read it as an operand. A candidate instruction waiting at issue presents up to two source register numbers and one destination register number, each with its own valid bit. The scoreboard compares the candidate against both records and raises three separate hazard flags: read-after-write, write-after-write and write-after-read. It also drives a single issue-allowed signal.

When the issue strobe is high and issue is allowed, the candidate is accepted. Its destination is marked as owed a result, and each valid source adds one pending read on its register. A completion port removes the result reservation of a finished instruction. Two operand-read report ports remove pending reads once an in-flight instruction has consumed its operands. Reports that arrive in the same cycle are applied before the hazard check, so a register freed in that cycle does not stall the candidate. Register 0 is hard-wired and is never tracked.

Top module: `regsb_scoreboard`

## Requirements
- R1: After reset no register holds a write reservation or a pending read, so any candidate sees all three hazard flags low and `issue_ok` high.
- R2: `haz_raw` is high when a valid, nonzero candidate source names a register that holds a write reservation, unless a completion for that register arrives in the same cycle.
- R3: `haz_waw` is high when the valid, nonzero candidate destination holds a write reservation, unless a completion for that register arrives in the same cycle.
- R4: `haz_war` is high when the valid, nonzero candidate destination still has a pending read count above zero after subtracting the read reports for it in the same cycle.
- R5: `issue_ok` is low whenever any hazard flag is high. An `issue_i` pulse while `issue_ok` is low changes no reservation and no count.
- R6: An accepted issue reserves the destination from the next cycle on. It adds one pending read for each valid nonzero source, so two reads when both sources name the same register.
- R7: A completion (`wb_vld`, `wb_reg`) removes that register's write reservation from the next cycle on.
- R8: When a completion and an accepted issue name the same destination in one cycle, the register is reserved afterwards.
- R9: Each read report lowers the pending read count of its register by one. A report against a count of zero is ignored, and the count does not wrap.
- R10: Register 0 is never reserved, never collects pending reads and never raises a hazard flag.
- R11: Each register counts at most 2**CNT_W-1 pending reads. `issue_ok` is low with no hazard flag set when the registered count of a valid nonzero source, plus the candidate's reads of that register, would exceed that limit. Read reports in the same cycle are not credited for this check.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_src_a | input | IDX_W | Candidate first source register |
| cand_src_a_vld | input | 1 | First source is used |
| cand_src_b | input | IDX_W | Candidate second source register |
| cand_src_b_vld | input | 1 | Second source is used |
| cand_dst | input | IDX_W | Candidate destination register |
| cand_dst_vld | input | 1 | Destination is written |
| issue_i | input | 1 | Request to issue the candidate |
| wb_vld | input | 1 | A result has been written back |
| wb_reg | input | IDX_W | Register whose reservation ends |
| rdone_a_vld | input | 1 | First operand-read report valid |
| rdone_a_reg | input | IDX_W | Register read by the first report |
| rdone_b_vld | input | 1 | Second operand-read report valid |
| rdone_b_reg | input | IDX_W | Register read by the second report |
| haz_raw | output | 1 | Read-after-write hazard on the candidate |
| haz_waw | output | 1 | Write-after-write hazard on the candidate |
| haz_war | output | 1 | Write-after-read hazard on the candidate |
| issue_ok | output | 1 | Candidate may issue this cycle |

## Verification
The checker watches a few properties on every cycle. `issue_ok` never coexists with a hazard flag. Register 0 stays untracked. A refused issue leaves both tables untouched when no report arrives. An accepted issue leaves its destination reserved, even against a same-cycle completion. A held reservation always surfaces as `haz_waw` unless it is being released. The bench scenarios cover the rest, each through a later candidate: the same-cycle bypass of completions and read reports, the read count that refuses to wrap below zero, the overflow stall at the counter limit, and the clearing of both tables by a mid-run reset.

// File: rtl/regsb_pkg.sv
package regsb_pkg;

    // Hazard summary produced by the comparison stage.
    typedef struct packed {
        logic raw;
        logic waw;
        logic war;
        logic over;
    } haz_t;

endpackage

// File: rtl/regsb_write_table.sv
module regsb_write_table #(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wb_vld,
    input  logic [IDX_W-1:0] wb_reg,
    input  logic             set_vld,
    input  logic [IDX_W-1:0] set_reg,
    output logic [NREG-1:0]  pend_q,
    output logic [NREG-1:0]  pend_eff
);

    typedef struct packed {
        logic [NREG-1:0] pend;
    } wt_state_t;

    wt_state_t st_d, st_q;

    // Per-register view with the same-cycle completion already removed.
    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_eff
            if (r == 0) begin : g_zero
                assign pend_eff[r] = 1'b0;
            end else begin : g_reg
                assign pend_eff[r] = st_q.pend[r] &
                                     ~(wb_vld && (wb_reg == IDX_W'(r)));
            end
        end
    endgenerate

    always_comb begin
        st_d.pend = pend_eff;
        if (set_vld && (set_reg != '0)) begin
            st_d.pend[set_reg] = 1'b1;
        end
        st_d.pend[0] = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q = st_q.pend;

endmodule

// File: rtl/regsb_read_table.sv
module regsb_read_table #(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG),
    parameter int CNT_W = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       src_a_vld,
    input  logic [IDX_W-1:0]           src_a,
    input  logic                       src_b_vld,
    input  logic [IDX_W-1:0]           src_b,
    input  logic                       take,
    input  logic                       dec_a_vld,
    input  logic [IDX_W-1:0]           dec_a,
    input  logic                       dec_b_vld,
    input  logic [IDX_W-1:0]           dec_b,
    output logic [NREG-1:0][CNT_W-1:0] cnt_q,
    output logic [NREG-1:0]            busy_eff,
    output logic                       over
);

    localparam int SUM_W = CNT_W + 1;
    localparam logic [SUM_W-1:0] CNT_MAX = SUM_W'((1 << CNT_W) - 1);

    typedef struct packed {
        logic [NREG-1:0][CNT_W-1:0] cnt;
    } rt_state_t;

    rt_state_t st_d, st_q;

    logic [NREG-1:0][CNT_W-1:0] after_rel;
    logic [NREG-1:0][CNT_W-1:0] next_cnt;

    genvar r;
    generate
        for (r = 0; r < NREG; r++) begin : g_cnt
            logic [SUM_W-1:0] rel;
            logic [SUM_W-1:0] cur;
            logic [SUM_W-1:0] left;
            logic [SUM_W-1:0] add;
            logic [SUM_W-1:0] nxt;
            if (r == 0) begin : g_zero
                assign rel  = '0;
                assign cur  = '0;
                assign left = '0;
                assign add  = '0;
                assign nxt  = '0;
            end else begin : g_reg
                assign rel  = SUM_W'(dec_a_vld && (dec_a == IDX_W'(r))) +
                              SUM_W'(dec_b_vld && (dec_b == IDX_W'(r)));
                assign cur  = SUM_W'(st_q.cnt[r]);
                // A report against an empty count is dropped, never wraps.
                assign left = (rel > cur) ? '0 : (cur - rel);
                assign add  = take ? (SUM_W'(src_a_vld && (src_a == IDX_W'(r))) +
                                      SUM_W'(src_b_vld && (src_b == IDX_W'(r))))
                                   : '0;
                assign nxt  = left + add;
            end
            assign after_rel[r] = left[CNT_W-1:0];
            assign busy_eff[r]  = (left != '0);
            assign next_cnt[r]  = nxt[CNT_W-1:0];
        end
    endgenerate

    // Headroom check on the registered counts.
    logic [SUM_W-1:0] need_a;
    logic [SUM_W-1:0] need_b;
    logic             over_a;
    logic             over_b;

    always_comb begin
        need_a = SUM_W'(st_q.cnt[src_a]) + SUM_W'(1) +
                 SUM_W'(src_b_vld && (src_b == src_a));
        need_b = SUM_W'(st_q.cnt[src_b]) + SUM_W'(1) +
                 SUM_W'(src_a_vld && (src_a == src_b));
        over_a = src_a_vld && (src_a != '0) && (need_a > CNT_MAX);
        over_b = src_b_vld && (src_b != '0) && (need_b > CNT_MAX);
        over   = over_a || over_b;
    end

    always_comb begin
        st_d.cnt = next_cnt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_q = st_q.cnt;

endmodule

// File: rtl/regsb_hazard_check.sv
module regsb_hazard_check
    import regsb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG)
) (
    input  logic             src_a_vld,
    input  logic [IDX_W-1:0] src_a,
    input  logic             src_b_vld,
    input  logic [IDX_W-1:0] src_b,
    input  logic             dst_vld,
    input  logic [IDX_W-1:0] dst,
    input  logic [NREG-1:0]  wr_eff,
    input  logic [NREG-1:0]  rd_busy,
    input  logic             rd_over,
    output haz_t             haz
);

    logic use_a;
    logic use_b;
    logic use_d;

    always_comb begin
        use_a    = src_a_vld && (src_a != '0);
        use_b    = src_b_vld && (src_b != '0);
        use_d    = dst_vld   && (dst   != '0);
        haz.raw  = (use_a && wr_eff[src_a]) || (use_b && wr_eff[src_b]);
        haz.waw  = use_d && wr_eff[dst];
        haz.war  = use_d && rd_busy[dst];
        haz.over = rd_over;
    end

endmodule

// File: rtl/regsb_scoreboard.sv
module regsb_scoreboard
    import regsb_pkg::*;
#(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG),
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] cand_src_a,
    input  logic             cand_src_a_vld,
    input  logic [IDX_W-1:0] cand_src_b,
    input  logic             cand_src_b_vld,
    input  logic [IDX_W-1:0] cand_dst,
    input  logic             cand_dst_vld,
    input  logic             issue_i,
    input  logic             wb_vld,
    input  logic [IDX_W-1:0] wb_reg,
    input  logic             rdone_a_vld,
    input  logic [IDX_W-1:0] rdone_a_reg,
    input  logic             rdone_b_vld,
    input  logic [IDX_W-1:0] rdone_b_reg,
    output logic             haz_raw,
    output logic             haz_waw,
    output logic             haz_war,
    output logic             issue_ok
);

    logic [NREG-1:0]            wr_pend_q;
    logic [NREG-1:0]            wr_eff;
    logic [NREG-1:0][CNT_W-1:0] rd_cnt_q;
    logic [NREG-1:0]            rd_busy;
    logic                       rd_over;
    logic                       take;
    haz_t                       haz;

    assign take = issue_i && issue_ok;

    regsb_write_table #(
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_wtab (
        .clk      (clk),
        .rst_n    (rst_n),
        .wb_vld   (wb_vld),
        .wb_reg   (wb_reg),
        .set_vld  (take && cand_dst_vld),
        .set_reg  (cand_dst),
        .pend_q   (wr_pend_q),
        .pend_eff (wr_eff)
    );

    regsb_read_table #(
        .NREG  (NREG),
        .IDX_W (IDX_W),
        .CNT_W (CNT_W)
    ) u_rtab (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_a_vld (cand_src_a_vld),
        .src_a     (cand_src_a),
        .src_b_vld (cand_src_b_vld),
        .src_b     (cand_src_b),
        .take      (take),
        .dec_a_vld (rdone_a_vld),
        .dec_a     (rdone_a_reg),
        .dec_b_vld (rdone_b_vld),
        .dec_b     (rdone_b_reg),
        .cnt_q     (rd_cnt_q),
        .busy_eff  (rd_busy),
        .over      (rd_over)
    );

    regsb_hazard_check #(
        .NREG  (NREG),
        .IDX_W (IDX_W)
    ) u_hchk (
        .src_a_vld (cand_src_a_vld),
        .src_a     (cand_src_a),
        .src_b_vld (cand_src_b_vld),
        .src_b     (cand_src_b),
        .dst_vld   (cand_dst_vld),
        .dst       (cand_dst),
        .wr_eff    (wr_eff),
        .rd_busy   (rd_busy),
        .rd_over   (rd_over),
        .haz       (haz)
    );

    assign haz_raw  = haz.raw;
    assign haz_waw  = haz.waw;
    assign haz_war  = haz.war;
    assign issue_ok = !(haz.raw || haz.waw || haz.war || haz.over);

endmodule

// File: rtl/regsb_checker.sv
module regsb_checker #(
    parameter int NREG  = 32,
    parameter int IDX_W = $clog2(NREG),
    parameter int CNT_W = 2
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [IDX_W-1:0]           cand_dst,
    input logic                       cand_dst_vld,
    input logic                       issue_i,
    input logic                       wb_vld,
    input logic [IDX_W-1:0]           wb_reg,
    input logic                       rdone_a_vld,
    input logic                       rdone_b_vld,
    input logic                       haz_raw,
    input logic                       haz_waw,
    input logic                       haz_war,
    input logic                       issue_ok,
    input logic [NREG-1:0]            wr_pend_q,
    input logic [NREG-1:0][CNT_W-1:0] rd_cnt_q
);

    // R5: permission and any hazard flag never coexist
    p_ok_blocked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        issue_ok |-> !(haz_raw || haz_waw || haz_war));

    // R5: a refused issue with no reports leaves both tables unchanged
    p_refused_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && !issue_ok && !wb_vld && !rdone_a_vld && !rdone_b_vld)
        |=> ($stable(wr_pend_q) && $stable(rd_cnt_q)));

    // R10: register 0 holds nothing
    p_zero_untracked_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_pend_q[0] && (rd_cnt_q[0] == '0)));

    // R6 and R8: an accepted issue leaves its destination reserved
    p_reserve_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_i && issue_ok && cand_dst_vld && (cand_dst != '0))
        |=> wr_pend_q[$past(cand_dst)]);

    // R7: a completion with no competing issue frees the register
    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_vld && !(issue_i && issue_ok && cand_dst_vld && (cand_dst == wb_reg)))
        |=> !wr_pend_q[$past(wb_reg)]);

    // R3: a held, unreleased reservation on the destination shows as WAW
    p_waw_seen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_dst_vld && (cand_dst != '0) && wr_pend_q[cand_dst] &&
         !(wb_vld && (wb_reg == cand_dst))) |-> haz_waw);

endmodule

bind regsb_scoreboard regsb_checker #(
    .NREG  (NREG),
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cand_dst     (cand_dst),
    .cand_dst_vld (cand_dst_vld),
    .issue_i      (issue_i),
    .wb_vld       (wb_vld),
    .wb_reg       (wb_reg),
    .rdone_a_vld  (rdone_a_vld),
    .rdone_b_vld  (rdone_b_vld),
    .haz_raw      (haz_raw),
    .haz_waw      (haz_waw),
    .haz_war      (haz_war),
    .issue_ok     (issue_ok),
    .wr_pend_q    (wr_pend_q),
    .rd_cnt_q     (rd_cnt_q)
);

// File: tb/regsb_scoreboard_tb.sv
module regsb_scoreboard_tb;

    localparam int NREG  = 32;
    localparam int IDX_W = 5;
    localparam int CNT_W = 2;

    typedef struct packed {
        logic [4:0] a;  logic av;
        logic [4:0] b;  logic bv;
        logic [4:0] d;  logic dv;
        logic       iss;
        logic       wv; logic [4:0] w;
        logic       rav; logic [4:0] ra;
        logic       rbv; logic [4:0] rb;
        logic [3:0] exp;   // {raw, waw, war, ok}
        logic [7:0] req;   // requirement number for messages
    } vec_t;

    function automatic vec_t mk(int a, int av, int b, int bv, int d, int dv,
                                int iss, int wv, int w, int rav, int ra,
                                int rbv, int rb, int exp, int req);
        vec_t v;
        v.a = 5'(a);  v.av = av[0];
        v.b = 5'(b);  v.bv = bv[0];
        v.d = 5'(d);  v.dv = dv[0];
        v.iss = iss[0];
        v.wv = wv[0]; v.w = 5'(w);
        v.rav = rav[0]; v.ra = 5'(ra);
        v.rbv = rbv[0]; v.rb = 5'(rb);
        v.exp = 4'(exp);
        v.req = 8'(req);
        return v;
    endfunction

    localparam int NV = 15;
    localparam vec_t VEC [NV] = '{
        mk(1,1, 2,1, 3,1, 1, 0,0, 0,0, 0,0, 'b0001, 6),  // R6 accepted issue
        mk(3,1, 0,0, 4,1, 1, 0,0, 0,0, 0,0, 'b1000, 2),  // R2 raw, refused
        mk(0,0, 0,0, 3,1, 0, 0,0, 0,0, 0,0, 'b0100, 3),  // R3 waw
        mk(0,0, 0,0, 1,1, 0, 0,0, 0,0, 0,0, 'b0010, 4),  // R4 war
        mk(0,0, 0,0, 1,1, 1, 0,0, 1,1, 0,0, 'b0001, 4),  // R4 read report bypass
        mk(0,0, 0,0, 4,1, 0, 0,0, 0,0, 0,0, 'b0001, 5),  // R5 refused issue left r4 free
        mk(1,1, 0,0, 0,0, 0, 1,1, 0,0, 0,0, 'b0001, 7),  // R7 same-cycle completion
        mk(1,1, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b0001, 7),  // R7 released
        mk(0,0, 0,0, 3,1, 1, 1,3, 0,0, 0,0, 'b0001, 8),  // R8 completion + issue
        mk(3,1, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b1000, 8),  // R8 new reservation holds
        mk(0,1, 0,1, 0,1, 1, 0,0, 0,0, 0,0, 'b0001, 10), // R10 register 0
        mk(0,0, 0,0, 0,1, 0, 0,0, 0,0, 0,0, 'b0001, 10), // R10 not reserved
        mk(0,0, 0,0, 0,0, 0, 0,0, 0,0, 1,2, 'b0001, 9),  // R9 release r2
        mk(0,0, 0,0, 2,1, 0, 0,0, 0,0, 1,2, 'b0001, 9),  // R9 release on zero
        mk(0,0, 0,0, 2,1, 0, 0,0, 0,0, 0,0, 'b0001, 9)   // R9 no wrap
    };

    logic             clk;
    logic             rst_n;
    logic [IDX_W-1:0] cand_src_a, cand_src_b, cand_dst, wb_reg, rdone_a_reg, rdone_b_reg;
    logic             cand_src_a_vld, cand_src_b_vld, cand_dst_vld, issue_i, wb_vld;
    logic             rdone_a_vld, rdone_b_vld;
    logic             haz_raw, haz_waw, haz_war, issue_ok;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    regsb_scoreboard #(.NREG(NREG), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .cand_src_a(cand_src_a), .cand_src_a_vld(cand_src_a_vld),
        .cand_src_b(cand_src_b), .cand_src_b_vld(cand_src_b_vld),
        .cand_dst(cand_dst), .cand_dst_vld(cand_dst_vld),
        .issue_i(issue_i), .wb_vld(wb_vld), .wb_reg(wb_reg),
        .rdone_a_vld(rdone_a_vld), .rdone_a_reg(rdone_a_reg),
        .rdone_b_vld(rdone_b_vld), .rdone_b_reg(rdone_b_reg),
        .haz_raw(haz_raw), .haz_waw(haz_waw), .haz_war(haz_war),
        .issue_ok(issue_ok)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    // Drive one vector at the falling edge, check 1 ns later, then let it clock in.
    task automatic step(input vec_t v, input string tag);
        logic [3:0] got;
        @(negedge clk);
        cand_src_a = v.a; cand_src_a_vld = v.av;
        cand_src_b = v.b; cand_src_b_vld = v.bv;
        cand_dst = v.d;   cand_dst_vld = v.dv;
        issue_i = v.iss;
        wb_vld = v.wv;    wb_reg = v.w;
        rdone_a_vld = v.rav; rdone_a_reg = v.ra;
        rdone_b_vld = v.rbv; rdone_b_reg = v.rb;
        #1;
        got = {haz_raw, haz_waw, haz_war, issue_ok};
        n_run++;
        if (got !== v.exp) begin
            n_fail++;
            $display("FAIL R%0d %s: got raw/waw/war/ok=%b expected %b",
                     v.req, tag, got, v.exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        step(mk(0,0, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b0001, 1), "idle in reset");
        step(mk(0,0, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b0001, 1), "idle in reset");
        rst_n = 1'b1;
        // R1: empty tables after reset
        step(mk(3,1, 3,1, 3,1, 0, 0,0, 0,0, 0,0, 'b0001, 1), "reset state r1_empty");

        for (int i = 0; i < NV; i++) begin
            step(VEC[i], $sformatf("vector %0d", i));
        end

        // R11: read counter limit on r5 (limit 3)
        step(mk(5,1, 5,1, 0,0, 1, 0,0, 0,0, 0,0, 'b0001, 6),  "R6 double read");
        step(mk(5,1, 0,0, 0,0, 1, 0,0, 0,0, 0,0, 'b0001, 11), "R11 reaches limit");
        step(mk(5,1, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b0000, 11), "R11 limit stall");
        step(mk(5,1, 0,0, 0,0, 1, 0,0, 1,5, 0,0, 'b0000, 11), "R11 report not credited");
        step(mk(5,1, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b0001, 11), "R11 headroom back");
        step(mk(0,0, 0,0, 5,1, 0, 0,0, 0,0, 0,0, 'b0010, 4),  "R4 two readers left");

        // R1: mid-run reset clears both tables
        @(negedge clk);
        rst_n = 1'b0;
        step(mk(0,0, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b0001, 1), "idle in reset");
        rst_n = 1'b1;
        step(mk(3,1, 0,0, 0,0, 0, 0,0, 0,0, 0,0, 'b0001, 1), "R1 write table cleared");
        step(mk(0,0, 0,0, 5,1, 0, 0,0, 0,0, 0,0, 'b0001, 1), "R1 read table cleared");

        @(negedge clk);
        finish_run();
    end

endmodule